// File: doc/BRIEF.md
# Lexical display register groups

This block is a small register file for a processor that runs nested closures. It holds two groups of eight 16-bit registers, called group A and group B. Group A holds the frame of the running block. Slot A0 points to the frame of the next enclosing lexical level, and slot A1 points to the level beyond that one, which is normally the home method. Slots A2 to A7 hold local variables. Group B is a scratch cache for variables that belong to an outer scope. The compiler loads an outer frame into group B and then works on it with ordinary register reads and writes.

Each group can be saved to a frame in memory or loaded from one with a single command. A save or load moves one word per cycle, and `busy` is high while it runs. Group B records the frame address it was last loaded from or saved to. When group B is loaded while its dirty bit is set, the block first writes the old contents back to the recorded frame, then fills the group from the new frame. The memory port is a simple request port: the memory must return read data in the same cycle as the request.

Top module: `scope_regfile`

## Requirements
- R1: After reset all sixteen registers read 0, `groupDirty` is 0, the recorded group B frame is 0, `busy` is 0 and `memReq` is 0.
- R2: `rdData` shows, within the same cycle, the register chosen by `rdGroup` (0 = group A, 1 = group B) and `rdIdx` (slot 0 to 7).
- R3: A write (`wrEn`) made while idle and without `cmdValid` stores `wrData` at the next clock edge. It also sets the dirty bit of that group (`groupDirty[0]` for A, `groupDirty[1]` for B).
- R4: `outerLink` always equals slot A0 (the next enclosing level) and `homeLink` always equals slot A1 (the level beyond that one).
- R5: A save (`cmdLoad`=0) is accepted at an idle edge. `busy` is then high for exactly 8 cycles. In cycle i of those 8 (i = 0 to 7), `memReq`=1 and `memWe`=1, `memAddr` = frame + i and `memWdata` = slot i. After the save, the group's dirty bit is 0.
- R6: A load (`cmdLoad`=1) of group A, or of a clean group B, keeps `busy` high for 8 cycles. In cycle i, `memReq`=1, `memWe`=0 and `memAddr` = frame + i, and slot i takes `memRdata` at the end of that cycle. After the load, the group's dirty bit is 0.
- R7: A load of group B while B is dirty keeps `busy` high for 16 cycles. The first 8 cycles write slots 0 to 7 to the recorded frame + i. The next 8 cycles read from the new frame as in R6.
- R8: A save or load of group B records its frame address as the target of later write-backs. A save or load of group A leaves that recorded address unchanged.
- R9: While `busy` is high, `wrEn` and `cmdValid` are ignored. No register, dirty bit or later transfer is affected by them.
- R10: When `cmdValid` and `wrEn` are both high in the same idle cycle, the command is accepted and the write is dropped.
- R11: Transfer addresses wrap modulo 2^ADDR_W, so a frame near the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| rdGroup | input | 1 | Read group select, 0 = A, 1 = B |
| rdIdx | input | 3 | Read slot select |
| rdData | output | 16 | Read data |
| wrEn | input | 1 | Register write strobe |
| wrGroup | input | 1 | Write group select |
| wrIdx | input | 3 | Write slot select |
| wrData | input | 16 | Write data |
| cmdValid | input | 1 | Save or load command strobe |
| cmdLoad | input | 1 | 1 = load group from memory, 0 = save group to memory |
| cmdGroup | input | 1 | Group the command acts on |
| cmdFrame | input | 16 | Frame base address of the command |
| busy | output | 1 | A transfer is in progress |
| groupDirty | output | 2 | Dirty bit per group, bit 0 = A, bit 1 = B |
| outerLink | output | 16 | Slot A0, link to the next enclosing level |
| homeLink | output | 16 | Slot A1, link to the level beyond |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid in the same cycle as a read request |

## Verification
The bench runs several kinds of transfer and compares the ports with a reference model on every cycle. Saves and loads of group A check the basic transfer order. A load of a dirty group B and a load of a clean group B differ only in whether the write-back happens, and each has its own `busy` length. Rewriting group B after a load and after a save shows which frame address each operation records as the write-back target. Commands and writes sent during `busy`, a write in the same cycle as a command, and a frame at the top of the address space cover the ignore rule, the priority rule and the address wrap.

// File: rtl/scope_pkg.sv
package scope_pkg;

  // Sequencer state of the transfer engine
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUT  = 2'd1,   // writing a group out to memory
    ST_GET  = 2'd2    // filling a group from memory
  } seqState_t;

  // Strobes from the sequencer to the register store
  typedef struct packed {
    logic userWr;   // accept the port write this cycle
    logic fillWr;   // store memRdata into the addressed slot
    logic finish;   // last beat of an operation: clear dirty, record frame
  } seqStrobe_t;

endpackage

// File: rtl/scope_seq.sv
module scope_seq
  import scope_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdLoad,
  input  logic              cmdGroup,
  input  logic [ADDR_W-1:0] cmdFrame,
  input  logic              wrEn,
  input  logic              dirtyB,
  input  logic [ADDR_W-1:0] tagB,
  output seqStrobe_t        strobe,
  output logic              opGroup,
  output logic [IDX_W-1:0]  opIdx,
  output logic [ADDR_W-1:0] opFrame,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr
);

  seqState_t         state;
  logic [IDX_W-1:0]  beat;
  logic              grp;
  logic              isLoad;
  logic [ADDR_W-1:0] frame;
  logic [ADDR_W-1:0] base;
  logic              lastBeat;

  assign lastBeat = (beat == IDX_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      beat   <= '0;
      grp    <= 1'b0;
      isLoad <= 1'b0;
      frame  <= '0;
      base   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            grp    <= cmdGroup;
            isLoad <= cmdLoad;
            frame  <= cmdFrame;
            beat   <= '0;
            if (!cmdLoad) begin
              state <= ST_PUT;
              base  <= cmdFrame;
            end else if (cmdGroup && dirtyB) begin
              state <= ST_PUT;   // write back old outer frame first
              base  <= tagB;
            end else begin
              state <= ST_GET;
              base  <= cmdFrame;
            end
          end
        end
        ST_PUT: begin
          beat <= beat + 1'b1;
          if (lastBeat) begin
            beat <= '0;
            if (isLoad) begin
              state <= ST_GET;
              base  <= frame;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_GET: begin
          beat <= beat + 1'b1;
          if (lastBeat) begin
            beat  <= '0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.userWr = (state == ST_IDLE) && wrEn && !cmdValid;
    strobe.fillWr = (state == ST_GET);
    strobe.finish = lastBeat &&
                    ((state == ST_GET) || ((state == ST_PUT) && !isLoad));
  end

  assign opGroup = grp;
  assign opIdx   = beat;
  assign opFrame = frame;
  assign busy    = (state != ST_IDLE);
  assign memReq  = busy;
  assign memWe   = (state == ST_PUT);
  assign memAddr = base + ADDR_W'(beat);

endmodule

// File: rtl/scope_store.sv
module scope_store
  import scope_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int GROUPS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              opGroup,
  input  logic [IDX_W-1:0]  opIdx,
  input  logic [ADDR_W-1:0] opFrame,
  input  logic              wrGroup,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              rdGroup,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] outerLink,
  output logic [DATA_W-1:0] homeLink,
  output logic [GROUPS-1:0] groupDirty,
  output logic [ADDR_W-1:0] tagB
);

  logic [DATA_W-1:0] grpRd  [GROUPS];
  logic [DATA_W-1:0] grpOut [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    logic [DATA_W-1:0] slot [SLOTS];
    logic              hitWr;
    logic              hitOp;

    assign hitWr = strobe.userWr && (wrGroup == 1'(g));
    assign hitOp = (opGroup == 1'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
      end else if (hitWr) begin
        slot[wrIdx] <= wrData;
      end else if (strobe.fillWr && hitOp) begin
        slot[opIdx] <= memRdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                        groupDirty[g] <= 1'b0;
      else if (hitWr)                   groupDirty[g] <= 1'b1;
      else if (strobe.finish && hitOp)  groupDirty[g] <= 1'b0;
    end

    assign grpRd[g]  = slot[rdIdx];
    assign grpOut[g] = slot[opIdx];

    if (g == 0) begin : gLinks
      assign outerLink = slot[0];
      assign homeLink  = slot[1];
    end
  end

  // Frame that group B currently mirrors; target of its write-back
  always_ff @(posedge clk) begin
    if (!rstN)                            tagB <= '0;
    else if (strobe.finish && opGroup)    tagB <= opFrame;
  end

  assign rdData   = grpRd[rdGroup];
  assign memWdata = grpOut[opGroup];

endmodule

// File: rtl/scope_regfile.sv
module scope_regfile
  import scope_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdGroup,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic              wrGroup,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cmdValid,
  input  logic              cmdLoad,
  input  logic              cmdGroup,
  input  logic [ADDR_W-1:0] cmdFrame,
  output logic              busy,
  output logic [1:0]        groupDirty,
  output logic [DATA_W-1:0] outerLink,
  output logic [DATA_W-1:0] homeLink,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  seqStrobe_t        strobe;
  logic              opGroup;
  logic [IDX_W-1:0]  opIdx;
  logic [ADDR_W-1:0] opFrame;
  logic [ADDR_W-1:0] tagB;

  scope_seq #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdLoad  (cmdLoad),
    .cmdGroup (cmdGroup),
    .cmdFrame (cmdFrame),
    .wrEn     (wrEn),
    .dirtyB   (groupDirty[1]),
    .tagB     (tagB),
    .strobe   (strobe),
    .opGroup  (opGroup),
    .opIdx    (opIdx),
    .opFrame  (opFrame),
    .busy     (busy),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr)
  );

  scope_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opGroup    (opGroup),
    .opIdx      (opIdx),
    .opFrame    (opFrame),
    .wrGroup    (wrGroup),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .memRdata   (memRdata),
    .rdGroup    (rdGroup),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .memWdata   (memWdata),
    .outerLink  (outerLink),
    .homeLink   (homeLink),
    .groupDirty (groupDirty),
    .tagB       (tagB)
  );

endmodule

// File: rtl/scope_regfile_chk.sv
module scope_regfile_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              wrEn,
  input logic              wrGroup,
  input logic              cmdValid,
  input logic [1:0]        groupDirty
);

  // R1: no memory traffic outside a transfer
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  // R3: an idle write without a command marks its group dirty
  assert_write_dirty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && !cmdValid) |=> groupDirty[$past(wrGroup)]);

  // R9: writes offered during a transfer never make a group dirty
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !$rose(groupDirty[0]) && !$rose(groupDirty[1]));

  // R5: a transfer only starts from an accepted command
  assert_start_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));

  // R11: beats of one direction step the address by one, with wrap
  assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq) && (memWe == $past(memWe)))
      |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

endmodule

bind scope_regfile scope_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .wrEn       (wrEn),
  .wrGroup    (wrGroup),
  .cmdValid   (cmdValid),
  .groupDirty (groupDirty)
);

// File: tb/tb_scope_regfile.sv
`timescale 1ns/1ps
module tb_scope_regfile;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rdGroup, wrEn, wrGroup, cmdValid, cmdLoad, cmdGroup;
  logic [2:0]  rdIdx, wrIdx;
  logic [15:0] rdData, wrData, cmdFrame, outerLink, homeLink;
  logic        busy, memReq, memWe;
  logic [1:0]  groupDirty;
  logic [15:0] memAddr, memWdata, memRdata;

  always #2.5 clk = ~clk;   // 200 MHz

  scope_regfile dut (.*);

  // ---------------- memory model ----------------
  logic [15:0] mem [256];
  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) if (memReq && memWe) mem[memAddr[7:0]] <= memWdata;
  function automatic logic [15:0] initWord(input int a);
    return 16'(16'h4000 + a * 7);
  endfunction

  // ---------------- check bookkeeping ----------------
  int checks = 0, errors = 0;
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] mRegs [2][8];
  logic [1:0]  mDirty;
  logic [15:0] mTag, mBase, mFrame;
  int          mPhase, mCnt;   // phase: 0 idle, 1 writing out, 2 reading in
  logic        mGrp, mLd;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < 2; g++) for (int i = 0; i < 8; i++) mRegs[g][i] = '0;
      mDirty = '0; mTag = '0; mPhase = 0; mCnt = 0; mBase = '0; mFrame = '0;
      mGrp = 0; mLd = 0;
    end else begin
      case (mPhase)
        0: if (cmdValid) begin
             mGrp = cmdGroup; mLd = cmdLoad; mFrame = cmdFrame; mCnt = 0;
             if (!cmdLoad) begin mPhase = 1; mBase = cmdFrame; end
             else if (cmdGroup && mDirty[1]) begin mPhase = 1; mBase = mTag; end
             else begin mPhase = 2; mBase = cmdFrame; end
           end else if (wrEn) begin
             mRegs[wrGroup][wrIdx] = wrData;
             mDirty[wrGroup] = 1'b1;
           end
        1: begin
             if (mCnt == 7) begin
               mCnt = 0;
               if (mLd) begin mPhase = 2; mBase = mFrame; end
               else begin
                 mPhase = 0; mDirty[mGrp] = 1'b0;
                 if (mGrp) mTag = mFrame;
               end
             end else mCnt++;
           end
        default: begin
             mRegs[mGrp][mCnt] = mem[8'(mBase + 16'(mCnt))];
             if (mCnt == 7) begin
               mCnt = 0; mPhase = 0; mDirty[mGrp] = 1'b0;
               if (mGrp) mTag = mFrame;
             end else mCnt++;
           end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R5 busy", busy, mPhase != 0);
      check("R6 memReq", memReq, mPhase != 0);
      if (mPhase != 0) begin
        check("R6 memWe", memWe, mPhase == 1);
        check("R11 memAddr", memAddr, 16'(mBase + 16'(mCnt)));
        if (mPhase == 1) check("R5 memWdata", memWdata, mRegs[mGrp][mCnt]);
      end
      check("R2 rdData", rdData, mRegs[rdGroup][rdIdx]);
      check("R4 outerLink", outerLink, mRegs[0][0]);
      check("R4 homeLink", homeLink, mRegs[0][1]);
      check("R3 groupDirty", groupDirty, mDirty);
    end
  end

  // ---------------- read selector: sweeps unless held ----------------
  logic       rdHold = 1'b0;
  logic [3:0] rdSel = '0;
  always @(posedge clk) begin
    #2;
    if (rdHold) {rdGroup, rdIdx} <= rdSel;
    else        {rdGroup, rdIdx} <= {rdGroup, rdIdx} + 4'd1;
  end

  // ---------------- stimulus tasks ----------------
  task automatic idleInputs();
    wrEn = 0; wrGroup = 0; wrIdx = 0; wrData = 0;
    cmdValid = 0; cmdLoad = 0; cmdGroup = 0; cmdFrame = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic writeReg(input logic g, input int i, input logic [15:0] d);
    wrEn = 1; wrGroup = g; wrIdx = 3'(i); wrData = d;
    step();
    idleInputs();
  endtask

  task automatic readReg(input logic g, input int i, output logic [15:0] d);
    rdSel = {g, 3'(i)}; rdHold = 1;
    @(posedge clk); #3;
    d = rdData;
    rdHold = 0;
  endtask

  task automatic runCmd(input logic ld, input logic g, input logic [15:0] f, output int n);
    cmdValid = 1; cmdLoad = ld; cmdGroup = g; cmdFrame = f;
    step();
    idleInputs();
    n = 0;
    while (busy) begin n++; step(); end
  endtask

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      finishRun();
    end
  end

  // ---------------- directed sequence ----------------
  logic [15:0] v;
  logic [15:0] aVals [8];
  logic [15:0] bVals [8];
  int n;

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = initWord(a);
    idleInputs();
    rdGroup = 0; rdIdx = 0;
    rstN = 0;
    repeat (3) step();
    rstN = 1;
    step();

    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 memReq", memReq, 0);
    check("R1 groupDirty", groupDirty, 2'b00);
    for (int i = 0; i < 8; i++) begin
      readReg(0, i, v); check("R1 A slot", v, 0);
      readReg(1, i, v); check("R1 B slot", v, 0);
    end

    // R2, R3, R4: fill both groups through the write port
    for (int i = 0; i < 8; i++) begin
      aVals[i] = 16'(16'hA100 + i * 16'h11);
      bVals[i] = 16'(16'hB200 + i * 16'h13);
      writeReg(0, i, aVals[i]);
      writeReg(1, i, bVals[i]);
    end
    check("R3 both groups dirty", groupDirty, 2'b11);
    for (int i = 0; i < 8; i++) begin
      readReg(1, i, v); check("R2 B readback", v, bVals[i]);
    end
    check("R4 outer link is A0", outerLink, aVals[0]);
    check("R4 home link is A1", homeLink, aVals[1]);

    // R5: save group A
    runCmd(0, 0, 16'h0020, n);
    check("R5 save length", n, 8);
    check("R5 A clean after save", groupDirty, 2'b10);
    for (int i = 0; i < 8; i++) check("R5 saved word", mem[8'h20 + i], aVals[i]);

    // R6: load group A (no write-back for A)
    runCmd(1, 0, 16'h0040, n);
    check("R6 load A length", n, 8);
    for (int i = 0; i < 8; i++) begin
      readReg(0, i, v); check("R6 A loaded", v, initWord(8'h40 + i));
    end

    // R7: dirty B load writes back to recorded frame 0 first
    runCmd(1, 1, 16'h0060, n);
    check("R7 dirty load length", n, 16);
    for (int i = 0; i < 8; i++) check("R7 written back", mem[i], bVals[i]);
    check("R7 B clean", groupDirty[1], 0);
    readReg(1, 5, v); check("R7 B filled", v, initWord(8'h65));

    // R8: write-back target is the frame B was loaded from
    writeReg(1, 3, 16'hC0DE);
    runCmd(1, 1, 16'h0080, n);
    check("R8 write-back to load frame", mem[8'h63], 16'hC0DE);

    // R8: save of B records its frame; save/load of A leaves it alone
    runCmd(0, 1, 16'h00A0, n);
    runCmd(0, 0, 16'h0090, n);
    writeReg(1, 0, 16'h7777);
    runCmd(1, 1, 16'h00C0, n);
    check("R8 write-back to save frame", mem[8'hA0], 16'h7777);
    check("R8 write-back length", n, 16);

    // R7: clean B load skips the write-back
    runCmd(1, 1, 16'h00E0, n);
    check("R7 clean load length", n, 8);

    // R9: writes and commands during busy are ignored
    readReg(0, 2, aVals[2]);
    cmdValid = 1; cmdLoad = 0; cmdGroup = 0; cmdFrame = 16'h0010;
    step();
    idleInputs();
    wrEn = 1; wrGroup = 0; wrIdx = 2; wrData = 16'hDEAD;
    cmdValid = 1; cmdLoad = 1; cmdGroup = 1; cmdFrame = 16'h0000;
    n = 0;
    while (busy) begin n++; step(); end
    idleInputs();
    check("R9 busy not extended", n, 8);
    readReg(0, 2, v); check("R9 write ignored", v, aVals[2]);
    check("R9 no dirty", groupDirty, 2'b00);
    step(); step();
    check("R9 no late transfer", busy, 0);

    // R10: command wins over a same-cycle write
    cmdValid = 1; cmdLoad = 0; cmdGroup = 0; cmdFrame = 16'h0030;
    wrEn = 1; wrGroup = 0; wrIdx = 2; wrData = 16'hBEEF;
    step();
    idleInputs();
    while (busy) step();
    readReg(0, 2, v); check("R10 write dropped", v, aVals[2]);
    check("R10 saved old value", mem[8'h32], aVals[2]);
    check("R10 clean", groupDirty, 2'b00);

    // R11: address wrap at the top of the space
    runCmd(0, 0, 16'hFFFE, n);
    readReg(0, 0, v); check("R11 wrap word0", mem[8'hFE], v);
    readReg(0, 2, v); check("R11 wrap word2", mem[8'h00], v);
    readReg(0, 7, v); check("R11 wrap word7", mem[8'h05], v);

    repeat (4) step();
    finishRun();
  end

endmodule